// File: doc/BRIEF.md
# Direct-Mapped Write-Through Page Cache

This block sits between a processor-side byte bus with a 16-bit address and a slow serial RAM controller. It keeps a local copy of up to 16 pages of 256 bytes each, for 4 KB of on-chip storage. Each address maps to exactly one line. The line is picked by address bits 11:8, bits 15:12 are held as the line's tag, and bits 7:0 pick the byte inside the page.

A read that hits is answered from local storage without touching the backing RAM. A read that misses asks the backing controller for the whole page as one burst, stores every byte in the selected line, and then answers. Every write goes through to the backing RAM. A write that hits also updates the local copy. A write that misses sends the byte first and then loads the page into its line. A miss flag is high for as long as a page fill is running, so an outside counter can count misses.

Top module: `page_cache`

## Requirements
- R1: Address bits 15:12 are the tag, bits 11:8 select one of 16 lines and bits 7:0 select the byte. Two addresses that differ only in the tag compete for the same line, and the newer page evicts the older one.
- R2: After reset every line is invalid, including tag 0. The first access to any page after reset, address 0x0000 included, is a miss.
- R3: On a read hit, `cpu_ready_o` rises in the cycle after the request is sampled and carries the stored byte. No backing request is issued.
- R4: On a read miss exactly one page read is issued (`mem_we_o`=0) at the address with bits 7:0 cleared. The 256 returned bytes fill offsets 0 to 255 in ascending order, and the answer is the byte at the requested offset.
- R5: On a write hit the local byte is updated and exactly one byte write (`mem_we_o`=1) is issued with the same address and data. A later read of that address hits and returns the new byte.
- R6: On a write miss a byte write is issued first and then a page read of the same page. After that the page hits, and reads return the written byte.
- R7: `cpu_ready_o` is high for exactly one cycle per access. It stays low while any backing request or fill is pending, and it is low out of reset.
- R8: `miss_o` is high from the cycle the page read is first requested through the cycle in which the last fill byte is accepted, and low at all other times.
- R9: The valid bits and tags change only in the cycle that accepts the last fill byte.
- R10: A backing request holds `mem_req_o`, address, data and `mem_we_o` stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 16 | Byte address |
| cpu_wdata_i | input | 8 | Write byte |
| cpu_rdata_o | output | 8 | Read byte, valid with ready |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| miss_o | output | 1 | High while a page fill is in progress |
| mem_req_o | output | 1 | Backing request, held until acknowledged |
| mem_we_o | output | 1 | 1 = byte write, 0 = page read |
| mem_addr_o | output | 16 | Byte address or page-aligned address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_ack_i | input | 1 | Request accepted (a write is then complete) |
| mem_rvalid_i | input | 1 | Fill byte valid |
| mem_rdata_i | input | 8 | Fill byte, in ascending offset order |

## Verification
Checks on every cycle cover the single-cycle ready pulse, the absence of backing traffic while ready is high, stable request fields until acknowledge, page-aligned read addresses, and the freeze of the valid bits outside the last fill beat. Only the bench's scenarios can show the functional behaviours. These are hit or miss after reset, the exact order of backing traffic for each of the four access kinds, the returned byte values after writes and evictions, and the alignment of `miss_o` with the fill. The bench does this with a behavioural tag model and a byte-level memory model.

// File: rtl/page_cache_pkg.sv
package page_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_FILL,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/page_cache_tags.sv
module page_cache_tags #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TAG_W-1:0] upd_tag_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (upd_en_i) begin
      valid_q[upd_idx_i] <= 1'b1;
      tag_q[upd_idx_i]   <= upd_tag_i;
    end
  end

  assign hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

  AST_VALID_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(valid_q)); // R9
endmodule

// File: rtl/page_cache_data.sv
module page_cache_data #(
  parameter int AW     = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/page_cache_ctrl.sv
module page_cache_ctrl
  import page_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic                   cpu_we_i,
  input  logic [ADDR_W-1:0]      cpu_addr_i,
  input  logic [DATA_W-1:0]      cpu_wdata_i,
  output logic [DATA_W-1:0]      cpu_rdata_o,
  output logic                   cpu_ready_o,
  output logic                   miss_o,
  input  logic                   hit_i,
  output logic                   upd_en_o,
  output logic [IDX_W-1:0]       upd_idx_o,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] upd_tag_o,
  output logic                   dst_we_o,
  output logic [IDX_W+OFF_W-1:0] dst_waddr_o,
  output logic [DATA_W-1:0]      dst_wdata_o,
  input  logic [DATA_W-1:0]      dst_rdata_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]      mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic                   mem_rvalid_i,
  input  logic [DATA_W-1:0]      mem_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  cache_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] byte_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              hit_q;
  logic              req_pend_q;
  logic              use_store_q;
  logic              last_beat;
  logic              wr_hit_now;

  assign last_beat  = (state_q == ST_FILL) && mem_rvalid_i && (&cnt_q);
  assign wr_hit_now = (state_q == ST_IDLE) && cpu_req_i && cpu_we_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      byte_q      <= '0;
      cnt_q       <= '0;
      hit_q       <= 1'b0;
      req_pend_q  <= 1'b0;
      use_store_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          addr_q      <= cpu_addr_i;
          wdata_q     <= cpu_wdata_i;
          hit_q       <= hit_i;
          cnt_q       <= '0;
          use_store_q <= !cpu_we_i && hit_i;
          if (cpu_we_i) begin
            state_q    <= ST_WRITE;
            req_pend_q <= 1'b1;
          end else if (hit_i) begin
            state_q <= ST_RESP;
          end else begin
            state_q    <= ST_FILL;
            req_pend_q <= 1'b1;
          end
        end
        ST_WRITE: if (mem_ack_i) begin
          // write miss chains straight into a page fill
          req_pend_q <= !hit_q;
          state_q    <= hit_q ? ST_RESP : ST_FILL;
        end
        ST_FILL: begin
          if (mem_ack_i) req_pend_q <= 1'b0;
          if (mem_rvalid_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == addr_q[OFF_W-1:0]) byte_q <= mem_rdata_i;
            if (&cnt_q) state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state_q == ST_FILL) begin
      dst_we_o    = mem_rvalid_i;
      dst_waddr_o = {addr_q[OFF_W +: IDX_W], cnt_q};
      dst_wdata_o = mem_rdata_i;
    end else begin
      dst_we_o    = wr_hit_now;
      dst_waddr_o = cpu_addr_i[IDX_W+OFF_W-1:0];
      dst_wdata_o = cpu_wdata_i;
    end
  end

  assign upd_en_o    = last_beat;
  assign upd_idx_o   = addr_q[OFF_W +: IDX_W];
  assign upd_tag_o   = addr_q[ADDR_W-1 -: TAG_W];

  assign cpu_ready_o = (state_q == ST_RESP);
  assign cpu_rdata_o = use_store_q ? dst_rdata_i : byte_q;
  assign miss_o      = (state_q == ST_FILL);

  assign mem_req_o   = ((state_q == ST_WRITE) || (state_q == ST_FILL)) && req_pend_q;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = (state_q == ST_WRITE) ? addr_q
                     : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = wdata_q;

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o); // R7
  AST_READY_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_req_o); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10
  AST_PAGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[OFF_W-1:0] == '0); // R4
  AST_MISS_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !cpu_ready_o); // R8
endmodule

// File: rtl/page_cache.sv
module page_cache #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              miss_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LAW   = IDX_W + OFF_W;

  logic              hit;
  logic              upd_en;
  logic [IDX_W-1:0]  upd_idx;
  logic [TAG_W-1:0]  upd_tag;
  logic              dst_we;
  logic [LAW-1:0]    dst_waddr;
  logic [DATA_W-1:0] dst_wdata;
  logic [DATA_W-1:0] dst_rdata;

  page_cache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (cpu_addr_i[OFF_W +: IDX_W]),
    .lk_tag_i  (cpu_addr_i[ADDR_W-1 -: TAG_W]),
    .hit_o     (hit),
    .upd_en_i  (upd_en),
    .upd_idx_i (upd_idx),
    .upd_tag_i (upd_tag)
  );

  page_cache_data #(.AW(LAW), .DATA_W(DATA_W)) i_data (
    .clk_i   (clk_i),
    .we_i    (dst_we),
    .waddr_i (dst_waddr),
    .wdata_i (dst_wdata),
    .raddr_i (cpu_addr_i[LAW-1:0]),
    .rdata_o (dst_rdata)
  );

  page_cache_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rdata_o  (cpu_rdata_o),
    .cpu_ready_o  (cpu_ready_o),
    .miss_o       (miss_o),
    .hit_i        (hit),
    .upd_en_o     (upd_en),
    .upd_idx_o    (upd_idx),
    .upd_tag_o    (upd_tag),
    .dst_we_o     (dst_we),
    .dst_waddr_o  (dst_waddr),
    .dst_wdata_o  (dst_wdata),
    .dst_rdata_i  (dst_rdata),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );
endmodule

// File: tb/test_page_cache.sv
`timescale 1ns/1ps
module test_page_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic [7:0]  cpu_rdata_o;
  logic        cpu_ready_o;
  logic        miss_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  page_cache i_page_cache (.*);

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit started = 0;

  // backing RAM as seen by the slave
  bit [7:0] bmem [int];
  // expected contents as seen by the reference model
  bit [7:0] emem [int];
  bit       mv [16];
  int       mt [16];

  int log_we[$];
  int log_addr[$];
  int log_data[$];

  function automatic bit [7:0] init_byte(int a);
    return 8'((a * 29) + (a >> 8) * 3 + 1);
  endfunction
  function automatic bit [7:0] bval(int a);
    return bmem.exists(a) ? bmem[a] : init_byte(a);
  endfunction
  function automatic bit [7:0] eval(int a);
    return emem.exists(a) ? emem[a] : init_byte(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // backing slave and per-cycle miss comparison
  initial begin
    int sl = 0;
    int dly = 0;
    int idx = 0;
    int tick = 0;
    int page = 0;
    bit rd = 0;
    bit fill_active = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
      if (started) begin
        mem_ack_i = 1'b0;
        mem_rvalid_i = 1'b0;
        case (sl)
          0: if (mem_req_o) begin
            log_we.push_back(mem_we_o);
            log_addr.push_back(mem_addr_o);
            log_data.push_back(mem_wdata_o);
            rd = !mem_we_o;
            page = mem_addr_o;
            if (rd) fill_active = 1;
            dly = 2;
            sl = 1;
          end
          1: begin
            dly--;
            if (dly == 0) begin
              mem_ack_i = 1'b1;
              if (rd) begin sl = 2; idx = 0; end
              else begin bmem[page] = mem_wdata_o; sl = 0; end
            end
          end
          2: begin
            tick++;
            if (tick % 37 != 5) begin
              mem_rvalid_i = 1'b1;
              mem_rdata_i = bval(page + idx);
              idx++;
              if (idx == 256) sl = 3;
            end
          end
          default: begin fill_active = 0; sl = 0; end
        endcase
        // R8: miss flag follows the fill window
        check(miss_o === fill_active, "R8 miss_o", miss_o, fill_active);
      end
    end
  end

  task automatic access(input bit we, input int a, input int d, input string lbl);
    int lb = log_addr.size();
    int ix = (a >> 8) & 15;
    int tg = (a >> 12) & 15;
    bit hit = mv[ix] && (mt[ix] == tg);
    int n = 0;
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = 16'(a); cpu_wdata_i = 8'(d);
    do begin @(negedge clk_i); n++; end while (!cpu_ready_o && n < 3000);
    cpu_req_i = 1'b0;
    check(n < 3000, {lbl, " R7 timeout"}, n, 3000);
    if (!we) begin
      check(cpu_rdata_o === eval(a), {lbl, hit ? " R3 hit data" : " R4 miss data"},
            cpu_rdata_o, eval(a));
      if (hit) begin
        check(n == 1, {lbl, " R3 latency"}, n, 1);
        check(log_addr.size() == lb, {lbl, " R3 no backing"}, log_addr.size() - lb, 0);
      end else begin
        check(log_addr.size() == lb + 1, {lbl, " R4 one burst"}, log_addr.size() - lb, 1);
        if (log_addr.size() == lb + 1) begin
          check(log_we[lb] == 0, {lbl, " R4 read kind"}, log_we[lb], 0);
          check(log_addr[lb] == (a & 16'hFF00), {lbl, " R4 page addr"}, log_addr[lb], a & 16'hFF00);
        end
      end
    end else begin
      int exp_n = hit ? 1 : 2;
      check(log_addr.size() == lb + exp_n, {lbl, hit ? " R5 count" : " R6 count"},
            log_addr.size() - lb, exp_n);
      if (log_addr.size() == lb + exp_n) begin
        check(log_we[lb] == 1 && log_addr[lb] == a && log_data[lb] == d,
              {lbl, hit ? " R5 write" : " R6 write first"}, log_addr[lb], a);
        if (!hit)
          check(log_we[lb+1] == 0 && log_addr[lb+1] == (a & 16'hFF00),
                {lbl, " R6 page read"}, log_addr[lb+1], a & 16'hFF00);
      end
    end
    @(negedge clk_i);
    check(cpu_ready_o === 1'b0, {lbl, " R7 pulse"}, cpu_ready_o, 0);
    if (we) emem[a] = 8'(d);
    if (!hit) begin mv[ix] = 1; mt[ix] = tg; end
  endtask

  initial begin
    int seed = 12345;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mt[i] = 0; end
    repeat (3) @(negedge clk_i);
    check(cpu_ready_o === 1'b0 && miss_o === 1'b0 && mem_req_o === 1'b0,
          "R7 reset outputs", {cpu_ready_o, miss_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    started = 1;
    access(0, 16'h0034, 0, "R2 tag0");
    access(0, 16'h0035, 0, "R3");
    access(0, 16'h00FF, 0, "R3 last");
    access(0, 16'h1234, 0, "R4");
    access(0, 16'h1200, 0, "R3 first");
    access(1, 16'h1240, 8'hAA, "R5");
    access(0, 16'h1240, 0, "R5 readback");
    access(1, 16'h3456, 8'h5C, "R6");
    access(0, 16'h3456, 0, "R6 readback");
    access(0, 16'h5234, 0, "R1 evict");
    access(0, 16'h1240, 0, "R1 conflict");
    access(0, 16'h5234, 0, "R9 refill");
    access(0, 16'hFFFF, 0, "R1 top");
    access(0, 16'hFF00, 0, "R3 top");
    for (int k = 0; k < 30; k++) begin
      int a;
      seed = seed * 1103515245 + 12345;
      a = (((seed >> 20) & 3) << 12) | ((2 + ((seed >> 18) & 1)) << 8) | ((seed >> 8) & 255);
      access(seed[25], a, (seed >> 3) & 255, "R1 mix");
    end
    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule